// File: doc/BRIEF.md
# Multicycle 16-bit Accumulator-Free Load/ALU Processor Core

This block is a small 16-bit processor core that runs each instruction as a fixed sequence of phases over one shared internal bus. It holds a program counter, an instruction register, a memory address register, a memory data register, three condition flags and an eight-entry register file. A control state machine steps through three fetch cycles, a decode cycle, and then the evaluation, read and write-back cycles that the opcode needs. The supported operations are ADD, AND and NOT, the loads LD, LDR and LDI, the address-forming LEA, the conditional branch BR and the register jump JMP.

The memory side is a read-only word port. In a cycle with `mem_en` high the memory returns the word at `mem_addr` on `mem_rdata` within that cycle, and the core captures it at the clock edge that ends the cycle. For each register write the core shows the destination index and value on a write-back trace (`wb_valid`, `wb_reg`, `wb_data`). It raises `instr_done` in the last cycle of every instruction. Integration code or a testbench can follow execution through these outputs without reaching inside.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC becomes 0x3000, the condition flags become Z only (`cc_nzp` = 3'b010), all eight registers become 0 and the sequencer returns to its first fetch cycle. In the first cycle after reset `mem_en` is low, and the first read then goes to 0x3000.
- R2: Every fetch takes three cycles. In cycle one, PC drives the bus, MAR loads it and PC becomes PC+1. In cycle two there is a single read at the instruction's own address. In cycle three the fetched word goes into the instruction register, which changes at no other time.
- R3: The number of memory reads per instruction, fetch included, is 1 for ADD, AND, NOT, LEA, BR and JMP, 2 for LD and LDR, and 3 for LDI. The third read of LDI uses as its address the word returned by the second.
- R4: An instruction takes 5 cycles for ADD, AND, NOT, LEA, BR and JMP, 7 for LD and LDR, and 9 for LDI.
- R5: ADD (opcode 4'b0001) and AND (4'b0101) write to register IR[11:9] the sum or bitwise AND of register IR[8:6] and a second operand. That operand is register IR[2:0] when IR[5]=0, or IR[4:0] sign-extended to 16 bits when IR[5]=1 (5'b10000 gives 0xFFF0, 5'b01001 gives 0x0009).
- R6: NOT (opcode 4'b1001) writes the bitwise complement of register IR[8:6] to register IR[11:9].
- R7: LD (4'b0010) and LDI (4'b1010) form their address as the incremented PC plus IR[8:0] sign-extended. LDR (4'b0110) forms it as register IR[8:6] plus IR[5:0] sign-extended. LEA (4'b1110) writes the incremented PC plus sign-extended IR[8:0] to register IR[11:9] and makes no data read.
- R8: Every register write also sets `cc_nzp` = {N,Z,P} from the written value: 3'b100 for negative, 3'b010 for zero and 3'b001 for positive. Exactly one flag is set at all times.
- R9: BR (opcode 4'b0000) loads PC with the incremented PC plus sign-extended IR[8:0] when (IR[11:9] & `cc_nzp`) is non-zero. Otherwise PC stays at the incremented value.
- R10: JMP (opcode 4'b1100) loads PC from register IR[8:6] in its final cycle.
- R11: Each ADD, AND, NOT, LEA, LD, LDR and LDI writes exactly one register, in its last cycle, with `wb_reg` = IR[11:9]. BR and JMP write no register. At most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_en | output | 1 | Memory read request for this cycle |
| mem_addr | output | 16 | Read address (memory address register) |
| mem_rdata | input | 16 | Word returned for the current request |
| wb_valid | output | 1 | A register is written at the end of this cycle |
| wb_reg | output | 3 | Index of the register being written |
| wb_data | output | 16 | Value being written |
| cc_nzp | output | 3 | Condition flags {N,Z,P} |
| pc_o | output | 16 | Current program counter |
| instr_done | output | 1 | Last cycle of the current instruction |

## Verification
The bench targets the three-read indirect load. A core that reused the pointer address would return the pointer word instead of the data, and one that skipped the second read would show a cycle count of 7 instead of 9. Immediates with the sign bit set, and an AND whose result is exactly zero, expose a missing sign extension or wrong flag logic as wrong values or wrong `cc_nzp`. A taken BR that hops over a word, a not-taken BR on a flag mismatch, a JMP and a backward branch are all checked through the next fetch address, so an off-by-one in the PC base or a wrong condition mask jumps to the wrong place. A reset in the middle of a run must bring the core back to 0x3000 with the flags at Z.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned RIDX_W = $clog2(NUM_REGS);

    localparam logic [3:0] OP_BR  = 4'b0000;
    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_LD  = 4'b0010;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_LDR = 4'b0110;
    localparam logic [3:0] OP_NOT = 4'b1001;
    localparam logic [3:0] OP_LDI = 4'b1010;
    localparam logic [3:0] OP_JMP = 4'b1100;
    localparam logic [3:0] OP_LEA = 4'b1110;

    typedef enum logic [3:0] {
        S_F1, S_F2, S_F3, S_DEC, S_ALU, S_LEA, S_EA,
        S_RD, S_PTR, S_RD2, S_WB, S_BR, S_JMP
    } state_e;

    typedef enum logic { PC_INC, PC_AGEN } pc_sel_e;
    typedef enum logic { BASE_PC, BASE_REG } base_sel_e;
    typedef enum logic [1:0] { OFF_ZERO, OFF_6, OFF_9 } off_sel_e;

    typedef struct packed {
        logic      gate_pc;
        logic      gate_mdr;
        logic      gate_alu;
        logic      gate_agen;
        logic      ld_pc;
        logic      ld_mar;
        logic      ld_mdr;
        logic      ld_ir;
        logic      ld_reg;
        logic      ld_cc;
        pc_sel_e   pc_sel;
        base_sel_e base_sel;
        off_sel_e  off_sel;
        logic      mem_en;
        logic      done;
    } ctl_t;

endpackage

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
    import mc16_pkg::*;
(
    input  state_e     state,
    input  logic [3:0] opc,
    input  logic [2:0] cond,
    input  logic [2:0] cc,
    output ctl_t       ctl,
    output state_e     nxt
);
    always_comb begin
        ctl = '0;
        nxt = S_F1;
        unique case (state)
            S_F1: begin
                ctl.gate_pc = 1'b1;
                ctl.ld_mar  = 1'b1;
                ctl.ld_pc   = 1'b1;
                ctl.pc_sel  = PC_INC;
                nxt         = S_F2;
            end
            S_F2: begin
                ctl.mem_en = 1'b1;
                ctl.ld_mdr = 1'b1;
                nxt        = S_F3;
            end
            S_F3: begin
                ctl.gate_mdr = 1'b1;
                ctl.ld_ir    = 1'b1;
                nxt          = S_DEC;
            end
            S_DEC: begin
                case (opc)
                    OP_ADD, OP_AND, OP_NOT: nxt = S_ALU;
                    OP_LEA:                 nxt = S_LEA;
                    OP_LD, OP_LDR, OP_LDI:  nxt = S_EA;
                    OP_BR:                  nxt = S_BR;
                    OP_JMP:                 nxt = S_JMP;
                    default: begin
                        ctl.done = 1'b1;
                        nxt      = S_F1;
                    end
                endcase
            end
            S_ALU: begin
                ctl.gate_alu = 1'b1;
                ctl.ld_reg   = 1'b1;
                ctl.ld_cc    = 1'b1;
                ctl.done     = 1'b1;
            end
            S_LEA: begin
                ctl.gate_agen = 1'b1;
                ctl.base_sel  = BASE_PC;
                ctl.off_sel   = OFF_9;
                ctl.ld_reg    = 1'b1;
                ctl.ld_cc     = 1'b1;
                ctl.done      = 1'b1;
            end
            S_EA: begin
                ctl.gate_agen = 1'b1;
                ctl.ld_mar    = 1'b1;
                if (opc == OP_LDR) begin
                    ctl.base_sel = BASE_REG;
                    ctl.off_sel  = OFF_6;
                end else begin
                    ctl.base_sel = BASE_PC;
                    ctl.off_sel  = OFF_9;
                end
                nxt = S_RD;
            end
            S_RD: begin
                ctl.mem_en = 1'b1;
                ctl.ld_mdr = 1'b1;
                nxt        = (opc == OP_LDI) ? S_PTR : S_WB;
            end
            S_PTR: begin
                ctl.gate_mdr = 1'b1;
                ctl.ld_mar   = 1'b1;
                nxt          = S_RD2;
            end
            S_RD2: begin
                ctl.mem_en = 1'b1;
                ctl.ld_mdr = 1'b1;
                nxt        = S_WB;
            end
            S_WB: begin
                ctl.gate_mdr = 1'b1;
                ctl.ld_reg   = 1'b1;
                ctl.ld_cc    = 1'b1;
                ctl.done     = 1'b1;
            end
            S_BR: begin
                ctl.done     = 1'b1;
                ctl.pc_sel   = PC_AGEN;
                ctl.base_sel = BASE_PC;
                ctl.off_sel  = OFF_9;
                ctl.ld_pc    = |(cond & cc);
            end
            S_JMP: begin
                ctl.done     = 1'b1;
                ctl.ld_pc    = 1'b1;
                ctl.pc_sel   = PC_AGEN;
                ctl.base_sel = BASE_REG;
                ctl.off_sel  = OFF_ZERO;
            end
            default: nxt = S_F1;
        endcase
    end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int unsigned W     = 16,
    parameter int unsigned NREG  = 8,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] rf_q [NREG];
    logic [W-1:0] rf_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            rf_d[i] = rf_q[i];
        end
        if (we) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            rf_q[i] <= rst ? '0 : rf_d[i];
        end
    end

    assign rd1 = rf_q[ra1];
    assign rd2 = rf_q[ra2];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned IMM_W = 5
) (
    input  logic [3:0]       opc,
    input  logic             imm_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b_reg,
    output logic [W-1:0]     y
);
    logic [W-1:0] b;

    always_comb begin
        b = imm_sel ? {{(W-IMM_W){imm[IMM_W-1]}}, imm} : b_reg;
        case (opc)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/mc16_agen.sv
module mc16_agen
    import mc16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  base_sel_e    base_sel,
    input  off_sel_e     off_sel,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base_reg,
    input  logic [8:0]   off_field,
    output logic [W-1:0] addr
);
    logic [W-1:0] base;
    logic [W-1:0] off;

    always_comb begin
        base = (base_sel == BASE_REG) ? base_reg : pc;
        case (off_sel)
            OFF_6:   off = {{(W-6){off_field[5]}}, off_field[5:0]};
            OFF_9:   off = {{(W-9){off_field[8]}}, off_field[8:0]};
            default: off = '0;
        endcase
        addr = base + off;
    end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input  logic        clk,
    input  logic        rst,
    output logic        mem_en,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic        wb_valid,
    output logic [2:0]  wb_reg,
    output logic [15:0] wb_data,
    output logic [2:0]  cc_nzp,
    output logic [15:0] pc_o,
    output logic        instr_done
);
    typedef struct packed {
        state_e              state;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   mar;
        logic [WORD_W-1:0]   mdr;
        logic [2:0]          cc;
    } regs_t;

    regs_t             r_q, r_d;
    ctl_t              ctl;
    state_e            nxt;
    logic [WORD_W-1:0] bus;
    logic [WORD_W-1:0] sr1_val, sr2_val, alu_y, agen_y;
    logic [3:0]        gate_vec;
    state_e            state_w;
    logic [WORD_W-1:0] ir_w;

    mc16_ctrl u_ctrl (
        .state (r_q.state),
        .opc   (r_q.ir[15:12]),
        .cond  (r_q.ir[11:9]),
        .cc    (r_q.cc),
        .ctl   (ctl),
        .nxt   (nxt)
    );

    mc16_regfile #(.W(WORD_W), .NREG(NUM_REGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (ctl.ld_reg),
        .wa  (r_q.ir[11:9]),
        .wd  (bus),
        .ra1 (r_q.ir[8:6]),
        .rd1 (sr1_val),
        .ra2 (r_q.ir[2:0]),
        .rd2 (sr2_val)
    );

    mc16_alu #(.W(WORD_W), .IMM_W(5)) u_alu (
        .opc     (r_q.ir[15:12]),
        .imm_sel (r_q.ir[5]),
        .imm     (r_q.ir[4:0]),
        .a       (sr1_val),
        .b_reg   (sr2_val),
        .y       (alu_y)
    );

    mc16_agen #(.W(WORD_W)) u_agen (
        .base_sel  (ctl.base_sel),
        .off_sel   (ctl.off_sel),
        .pc        (r_q.pc),
        .base_reg  (sr1_val),
        .off_field (r_q.ir[8:0]),
        .addr      (agen_y)
    );

    assign gate_vec = {ctl.gate_pc, ctl.gate_mdr, ctl.gate_alu, ctl.gate_agen};

    always_comb begin
        bus = ({WORD_W{ctl.gate_pc}}   & r_q.pc)
            | ({WORD_W{ctl.gate_mdr}}  & r_q.mdr)
            | ({WORD_W{ctl.gate_alu}}  & alu_y)
            | ({WORD_W{ctl.gate_agen}} & agen_y);
    end

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt;
        if (ctl.ld_pc) begin
            r_d.pc = (ctl.pc_sel == PC_INC) ? r_q.pc + 1'b1 : agen_y;
        end
        if (ctl.ld_mar) r_d.mar = bus;
        if (ctl.ld_mdr) r_d.mdr = mem_rdata;
        if (ctl.ld_ir)  r_d.ir  = bus;
        if (ctl.ld_cc) begin
            r_d.cc = {bus[WORD_W-1], (bus == '0), (!bus[WORD_W-1] && bus != '0)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= S_F1;
            r_q.pc    <= RESET_PC;
            r_q.ir    <= '0;
            r_q.mar   <= '0;
            r_q.mdr   <= '0;
            r_q.cc    <= 3'b010;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_w    = r_q.state;
    assign ir_w       = r_q.ir;
    assign mem_en     = ctl.mem_en;
    assign mem_addr   = r_q.mar;
    assign wb_valid   = ctl.ld_reg;
    assign wb_reg     = r_q.ir[11:9];
    assign wb_data    = bus;
    assign cc_nzp     = r_q.cc;
    assign pc_o       = r_q.pc;
    assign instr_done = ctl.done;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
    import mc16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input logic        clk,
    input logic        rst,
    input state_e      state,
    input logic [3:0]  gates,
    input logic [15:0] ir,
    input logic [15:0] pc,
    input logic        mem_en,
    input logic        wb_valid,
    input logic        done,
    input logic [2:0]  cc
);
    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == RESET_PC && state == S_F1 && cc == 3'b010));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_F1) |=> (pc == $past(pc) + 16'd1));

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state != S_F3) |=> $stable(ir));

    assert_read_phase_R3: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (state == S_F2 || state == S_RD || state == S_RD2));

    assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1);

    assert_write_last_R11: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    assert_single_driver_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gates));
endmodule

bind mc16_core mc16_core_chk #(.RESET_PC(RESET_PC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .state    (state_w),
    .gates    (gate_vec),
    .ir       (ir_w),
    .pc       (pc_o),
    .mem_en   (mem_en),
    .wb_valid (wb_valid),
    .done     (instr_done),
    .cc       (cc_nzp)
);

// File: tb/mc16_core_tb.sv
module mc16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en, wb_valid, instr_done;
    logic [15:0] mem_addr, mem_rdata, wb_data, pc_o;
    logic [2:0]  wb_reg, cc_nzp;

    always #2.5 clk = ~clk;

    mc16_core dut_i (
        .clk(clk), .rst(rst), .mem_en(mem_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .wb_data(wb_data), .cc_nzp(cc_nzp), .pc_o(pc_o), .instr_done(instr_done)
    );

    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];

    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] fetch;
        logic [3:0]  acc;
        logic [3:0]  cyc;
        logic        wb;
        logic [2:0]  rg;
        logic [15:0] data;
        logic [2:0]  cc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{16'hE21F, 16'h3000, 4'd1, 4'd5, 1'b1, 3'd1, 16'h3020, 3'b001},
        '{16'h6441, 16'h3001, 4'd2, 4'd7, 1'b1, 3'd2, 16'h3022, 3'b001},
        '{16'hA61E, 16'h3002, 4'd3, 4'd9, 1'b1, 3'd3, 16'h8001, 3'b100},
        '{16'h281C, 16'h3003, 4'd2, 4'd7, 1'b1, 3'd4, 16'h1234, 3'b001},
        '{16'h1B30, 16'h3004, 4'd1, 4'd5, 1'b1, 3'd5, 16'h1224, 3'b001},
        '{16'h1CC4, 16'h3005, 4'd1, 4'd5, 1'b1, 3'd6, 16'h9235, 3'b100},
        '{16'h5F29, 16'h3006, 4'd1, 4'd5, 1'b1, 3'd7, 16'h0000, 3'b010},
        '{16'h0401, 16'h3007, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0000, 3'b010},
        '{16'h913F, 16'h3009, 4'd1, 4'd5, 1'b1, 3'd0, 16'hEDCB, 3'b100},
        '{16'h0205, 16'h300A, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0000, 3'b100},
        '{16'h5480, 16'h300B, 4'd1, 4'd5, 1'b1, 3'd2, 16'h2002, 3'b001},
        '{16'h127F, 16'h300C, 4'd1, 4'd5, 1'b1, 3'd1, 16'h301F, 3'b001},
        '{16'hC040, 16'h300D, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0000, 3'b001},
        '{16'h0FEE, 16'h301F, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0000, 3'b001},
        '{16'h16E1, 16'h300E, 4'd1, 4'd5, 1'b1, 3'd3, 16'h8002, 3'b100},
        '{16'h0FFF, 16'h300F, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0000, 3'b100}
    };

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-instruction records gathered at falling edges
    int          n_done = 0;
    int          cyc_c = 0, acc_c = 0;
    logic [15:0] fa_c, la_c, wd_c;
    logic [2:0]  wr_c;
    logic        wv_c;
    logic [15:0] r_fetch [NV];
    logic [15:0] r_last  [NV];
    logic [15:0] r_data  [NV];
    logic [3:0]  r_acc   [NV];
    logic [3:0]  r_cyc   [NV];
    logic [2:0]  r_rg    [NV];
    logic [2:0]  r_cc    [NV];
    logic        r_wb    [NV];
    logic        rec_on = 1'b0;

    always @(negedge clk) begin
        if (rst || !rec_on) begin
            cyc_c = 0; acc_c = 0; wv_c = 1'b0;
        end else begin
            cyc_c++;
            if (mem_en) begin
                if (acc_c == 0) fa_c = mem_addr;
                la_c = mem_addr;
                acc_c++;
            end
            if (wb_valid) begin
                wv_c = 1'b1; wr_c = wb_reg; wd_c = wb_data;
            end
            if (instr_done) begin
                if (n_done < NV) begin
                    r_fetch[n_done] = fa_c; r_last[n_done] = la_c;
                    r_acc[n_done] = 4'(acc_c); r_cyc[n_done] = 4'(cyc_c);
                    r_wb[n_done] = wv_c; r_rg[n_done] = wr_c; r_data[n_done] = wd_c;
                end
                n_done++;
                cyc_c = 0; acc_c = 0; wv_c = 1'b0;
            end
        end
    end

    initial begin
        int wd;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        for (int i = 0; i < NV; i++) mem[TBL[i].fetch[7:0]] = TBL[i].instr;
        mem[8'h08] = 16'h1021;
        mem[8'h20] = 16'h1234;
        mem[8'h21] = 16'h3022;
        mem[8'h22] = 16'h8001;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rec_on = 1'b1;
        @(negedge clk);
        // R1: reset state seen in the first cycle
        chk("R1 pc", pc_o, 16'h3000);
        chk("R1 mem_en", {15'd0, mem_en}, 16'd0);
        chk("R1 cc", {13'd0, cc_nzp}, 16'h0002);
        chk("R1 wb_valid", {15'd0, wb_valid}, 16'd0);

        wd = 0;
        while (n_done < NV && wd < 3000) begin
            @(negedge clk);
            if (instr_done && n_done <= NV) r_cc[n_done - 1] = 3'bxxx;
            wd++;
        end
        @(negedge clk);
        if (wd >= 3000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d instructions", n_done, NV);
        end

        // walk the vector table
        for (int i = 0; i < NV; i++) begin
            chk("R2/R9/R10 fetch address", r_fetch[i], TBL[i].fetch);
            chk("R3 read count", {12'd0, r_acc[i]}, {12'd0, TBL[i].acc});
            chk("R4 cycle count", {12'd0, r_cyc[i]}, {12'd0, TBL[i].cyc});
            chk("R11 write flag", {15'd0, r_wb[i]}, {15'd0, TBL[i].wb});
            if (TBL[i].wb) begin
                chk("R11 dest index", {13'd0, r_rg[i]}, {13'd0, TBL[i].rg});
                chk("R5/R6/R7 result", r_data[i], TBL[i].data);
            end
        end
        // R3: indirect load's third read goes to the pointer value
        chk("R3 LDI final address", r_last[2], 16'h3022);
        // R8: flags after the final ADD producing 0x8002
        chk("R8 flags at end", {13'd0, cc_nzp}, {13'd0, TBL[NV-1].cc});

        // R1: reset in the middle of a run
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 pc after mid reset", pc_o, 16'h3000);
        chk("R1 cc after mid reset", {13'd0, cc_nzp}, 16'h0002);
        chk("R1 no read in first cycle", {15'd0, mem_en}, 16'd0);
        @(negedge clk);
        chk("R2 fetch read address", mem_addr, 16'h3000);
        chk("R2 fetch read strobe", {15'd0, mem_en}, 16'd1);
        chk("R2 pc incremented", pc_o, 16'h3001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule